// File: doc/BRIEF.md
# Branch Condition Evaluator with Loop Counter

This block settles whether a conditional branch is taken. It holds a 32-bit loop counter and receives a strobe along with a 5-bit options field, a 5-bit index into a 32-bit condition word, and the condition word itself. Two tests are combined. The first, when the options ask for it, decrements the counter and tests the new value for zero. The second, unless the options disable it, compares one selected condition bit with an expected polarity. The branch is taken only when both tests pass.

The result appears one cycle after the strobe as a valid pulse with a taken flag. If a decrement was requested, the counter holds its decremented value from that same edge. Software-style move operations can load the counter and read it back. A load in the same cycle as a decrement wins.

Top module: `br_cond_unit`

## Requirements
- R1: After reset the counter reads 0, and valid_o and taken_o are 0.
- R2: With opt_i[2]=0, an evaluation writes counter-1 into the counter, wrapping 0 to 0xFFFFFFFF. With opt_i[2]=1 the counter is left unchanged.
- R3: With opt_i[2]=0, the counter test passes when (counter-1 != 0) XOR opt_i[1]. With opt_i[2]=1 the counter test always passes.
- R4: With opt_i[4]=1 the condition test always passes. With opt_i[4]=0 it passes when cond_i[31-idx_i] equals opt_i[3], so index 0 selects the most significant bit.
- R5: taken_o is 1 only when both tests pass.
- R6: valid_o is 1 exactly one cycle after eval_i, and taken_o is 0 whenever valid_o is 0.
- R7: When ctr_we_i is 1, the counter takes ctr_wdata_i at the next edge. This overrides a decrement in the same cycle, but that evaluation still uses the counter's old value for its test.
- R8: ctr_o always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| eval_i | input | 1 | evaluation strobe |
| opt_i | input | 5 | branch options field |
| idx_i | input | 5 | condition bit index (0 = MSB) |
| cond_i | input | 32 | condition word |
| ctr_we_i | input | 1 | counter load enable |
| ctr_wdata_i | input | 32 | counter load value |
| ctr_o | output | 32 | counter read value |
| valid_o | output | 1 | result valid pulse |
| taken_o | output | 1 | branch taken |

## Verification
The bench steers the counter to 1 so that the decrement lands exactly on zero. A design that tests the old value before decrementing would disagree there. It also loads 0 and decrements to check the wrap to all ones. It sweeps the index across both ends of the condition word, which exposes a design that reverses the bit numbering. Same-cycle loads and evaluations show whether a design lets the decrement win, or tests the loaded value instead of the old one. Random option fields cover mistakes in polarity on either test.

// File: rtl/br_cond_pkg.sv
package br_cond_pkg;
  parameter int unsigned CTR_W  = 32;
  parameter int unsigned COND_W = 32;
  parameter int unsigned IDX_W  = $clog2(COND_W);
  localparam int unsigned OPT_COND_OFF = 4;
  localparam int unsigned OPT_COND_POL = 3;
  localparam int unsigned OPT_CTR_OFF  = 2;
  localparam int unsigned OPT_CTR_ZERO = 1;
  typedef struct packed {
    logic ctr_pass;
    logic cond_pass;
  } br_tests_t;
endpackage

// File: rtl/br_ctr_test.sv
module br_ctr_test
  import br_cond_pkg::*;
(
  input  logic [CTR_W-1:0] ctr_i,
  input  logic             skip_i,
  input  logic             want_zero_i,
  output logic [CTR_W-1:0] ctr_dec_o,
  output logic             pass_o
);
  assign ctr_dec_o = ctr_i - CTR_W'(1);
  assign pass_o = skip_i | ((ctr_dec_o != '0) ^ want_zero_i);
endmodule

// File: rtl/br_cond_test.sv
module br_cond_test
  import br_cond_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              skip_i,
  input  logic              pol_i,
  output logic              pass_o
);
  logic [COND_W-1:0] rev;
  logic              bit_sel;
  // bit 0 of the index space is the MSB
  for (genvar g = 0; g < COND_W; g++) begin : g_rev
    assign rev[g] = cond_i[COND_W-1-g];
  end
  assign bit_sel = rev[idx_i];
  assign pass_o  = skip_i | (bit_sel == pol_i);
endmodule

// File: rtl/br_cond_unit.sv
module br_cond_unit
  import br_cond_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [4:0]        opt_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              ctr_we_i,
  input  logic [CTR_W-1:0]  ctr_wdata_i,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              valid_o,
  output logic              taken_o
);
  logic [CTR_W-1:0] ctr_q, ctr_dec;
  br_tests_t        tests;

  br_ctr_test u_ctr_test (
    .ctr_i       (ctr_q),
    .skip_i      (opt_i[OPT_CTR_OFF]),
    .want_zero_i (opt_i[OPT_CTR_ZERO]),
    .ctr_dec_o   (ctr_dec),
    .pass_o      (tests.ctr_pass)
  );

  br_cond_test u_cond_test (
    .cond_i (cond_i),
    .idx_i  (idx_i),
    .skip_i (opt_i[OPT_COND_OFF]),
    .pol_i  (opt_i[OPT_COND_POL]),
    .pass_o (tests.cond_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q   <= '0;
      valid_o <= 1'b0;
      taken_o <= 1'b0;
    end else begin
      if (ctr_we_i)                              ctr_q <= ctr_wdata_i;
      else if (eval_i && !opt_i[OPT_CTR_OFF])    ctr_q <= ctr_dec;
      valid_o <= eval_i;
      taken_o <= eval_i & tests.ctr_pass & tests.cond_pass;
    end
  end

  assign ctr_o = ctr_q;
endmodule

// File: rtl/br_cond_unit_chk.sv
module br_cond_unit_chk
  import br_cond_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eval_i,
  input logic [4:0]        opt_i,
  input logic              ctr_we_i,
  input logic [CTR_W-1:0]  ctr_wdata_i,
  input logic [CTR_W-1:0]  ctr_o,
  input logic              valid_o,
  input logic              taken_o
);
  assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> valid_o);
  assert_no_spurious_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> !valid_o);
  assert_taken_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !taken_o);
  assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_we_i |=> ctr_o == $past(ctr_wdata_i));
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !opt_i[2] && !ctr_we_i) |=> ctr_o == $past(ctr_o) - 32'd1);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctr_we_i && !(eval_i && !opt_i[2])) |=> $stable(ctr_o));
  assert_all_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && opt_i[4] && opt_i[2]) |=> taken_o);
endmodule

bind br_cond_unit br_cond_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval_i), .opt_i(opt_i),
  .ctr_we_i(ctr_we_i), .ctr_wdata_i(ctr_wdata_i), .ctr_o(ctr_o),
  .valid_o(valid_o), .taken_o(taken_o)
);

// File: tb/br_cond_unit_tb.sv
module br_cond_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        eval = 0, we = 0;
  logic [4:0]  opt = 0, idx = 0;
  logic [31:0] cond = 0, wdata = 0;
  logic [31:0] ctr;
  logic        valid, taken;
  int errors = 0, checks = 0;
  longint m_ctr = 0;
  bit m_valid = 0, m_taken = 0;

  always #4 clk = ~clk;

  br_cond_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .opt_i(opt), .idx_i(idx),
    .cond_i(cond), .ctr_we_i(we), .ctr_wdata_i(wdata), .ctr_o(ctr),
    .valid_o(valid), .taken_o(taken)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural model, evaluated at the edge from the applied inputs
  task automatic model_step();
    longint nd;
    bit cp, bp, cb;
    nd = (m_ctr == 0) ? 64'hFFFF_FFFF : m_ctr - 1;
    cp = opt[2] ? 1 : ((nd != 0) ^ opt[1]);
    cb = cond[31 - idx];
    bp = opt[4] ? 1 : (cb == opt[3]);
    m_valid = eval;
    m_taken = eval && cp && bp;
    if (we) m_ctr = wdata;
    else if (eval && !opt[2]) m_ctr = nd;
  endtask

  // apply inputs, clock once, compare after edge
  task automatic step(bit e, bit [4:0] o, bit [4:0] i, bit [31:0] c, bit w, bit [31:0] d, string req);
    eval = e; opt = o; idx = i; cond = c; we = w; wdata = d;
    @(posedge clk);
    model_step();
    #2;
    chk({req, " valid"}, valid, m_valid);
    chk({req, " taken"}, taken, m_taken);
    chk({req, " ctr R8"}, ctr, m_ctr);
  endtask

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog act=hang exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2;
    chk("R1 ctr", ctr, 0); chk("R1 valid", valid, 0); chk("R1 taken", taken, 0);
    #20 rst_n = 1;
    @(negedge clk);
    // R2 wrap: decrement from 0
    step(1, 5'b10000, 0, 0, 0, 0, "R2 wrap");
    // R7 load, then decrement to zero with want-zero set
    step(0, 0, 0, 0, 1, 32'd1, "R7 load");
    step(1, 5'b10010, 0, 0, 0, 0, "R3 zero hit");
    step(0, 0, 0, 0, 1, 32'd1, "R7 load");
    step(1, 5'b10000, 0, 0, 0, 0, "R3 zero miss");
    // R4 index ends
    step(1, 5'b01100, 0, 32'h8000_0000, 0, 0, "R4 msb");
    step(1, 5'b01100, 31, 32'h8000_0000, 0, 0, "R4 lsb");
    step(1, 5'b00100, 31, 32'h0000_0001, 0, 0, "R4 pol0");
    // R7 same-cycle load vs decrement
    step(0, 0, 0, 0, 1, 32'd5, "R7 load");
    step(1, 5'b10000, 0, 0, 1, 32'd1, "R7 override");
    step(1, 5'b10010, 0, 0, 0, 0, "R5 both");
    // R2 hold when opt[2]=1
    step(1, 5'b10100, 0, 0, 0, 0, "R2 hold");
    step(0, 5'b10100, 0, 0, 0, 0, "R6 idle");
    for (int k = 0; k < 300; k++) begin
      bit [31:0] r = $urandom;
      step($urandom_range(0,3) != 0, 5'($urandom), 5'($urandom), r,
           $urandom_range(0,9) == 0, $urandom_range(0,3), "R5 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule